// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This block follows a processor core through its idle power states and drives the controls that go with each state: the core clock gate, the PLL enable, a flag saying whether bus snoops may be serviced, and a permission telling the platform it may stop the bus clock. All requests come in on active-low lines: clock stop, sleep ("nap"), deep sleep and reset. Three strobes report bus activity: an incoming snoop, an incoming interrupt, and the servicing of a snoop or latching of an interrupt.

The states run in a fixed ladder. The running state drops to a clock-stopped grant state. From there the core can briefly service a snoop, or go down to sleep, and from sleep down to deep sleep. Leaving deep sleep passes through a timed PLL relock wait before the block reports sleep again. A request that arrives out of order, or bus activity while the core cannot respond, raises a one-cycle violation pulse and does not move the state. The reset request acts at once from any state, sleep included, without passing through the grant state.

Top module: `lps_seq`

## Requirements
- R1: `state_o` carries the state as RUN=0, STOP_GRANT=1, SNOOP=2, SLEEP=3, DEEP_SLEEP=4, RELOCK=5, RESET=6.
- R2: While `rst_req_n` is low the state is RESET at once, without waiting for a clock edge and from any state including SLEEP. The state becomes RUN at the first rising clock edge after release. Both permissions and `proto_err` are low in RESET.
- R3: In RUN, a low `clkstop_req_n` moves the state to STOP_GRANT. In STOP_GRANT with no other request active, a high `clkstop_req_n` returns it to RUN.
- R4: In STOP_GRANT, `snoop_req` or `irq_req` moves the state to SNOOP. This has priority over the other requests. SNOOP returns to STOP_GRANT on `snoop_done` or `irq_latched`.
- R5: A low `nap_req_n` in STOP_GRANT enters SLEEP. A low `nap_req_n` in RUN or SNOOP is a violation and does not move the state.
- R6: In SLEEP with `deep_req_n` high, a high `nap_req_n` returns the state to STOP_GRANT.
- R7: A low `deep_req_n` in SLEEP enters DEEP_SLEEP. A low `deep_req_n` in RUN, STOP_GRANT or SNOOP is a violation.
- R8: A high `deep_req_n` in DEEP_SLEEP enters RELOCK. RELOCK lasts exactly CLK_MHZ*RELOCK_US cycles and then gives SLEEP. A low `deep_req_n` during RELOCK returns the state to DEEP_SLEEP, and the next relock wait is a full one.
- R9: `snoop_req` or `irq_req` in SLEEP, DEEP_SLEEP or RELOCK is a violation and does not move the state.
- R10: `core_clk_en` is high only in RUN. `pll_en` is low only in DEEP_SLEEP. `snoop_ok` is high only in RUN, STOP_GRANT and SNOOP.
- R11: `bclk_stop_ok` is high only in DEEP_SLEEP. It rises no later than BCLK_STOP_LAG rising edges (1 or 2) after the edge that samples a low `deep_req_n` in SLEEP. It is low once the state has left DEEP_SLEEP.
- R12: `proto_err` is high for exactly the cycle after the edge that sampled a violation, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_req_n | input | 1 | Reset request, active low, asynchronous assert |
| clkstop_req_n | input | 1 | Clock-stop request, active low |
| nap_req_n | input | 1 | Sleep request, active low |
| deep_req_n | input | 1 | Deep-sleep request, active low |
| snoop_req | input | 1 | Bus snoop arrived (strobe) |
| irq_req | input | 1 | Interrupt arrived (strobe) |
| snoop_done | input | 1 | Snoop serviced by any agent (strobe) |
| irq_latched | input | 1 | Interrupt latched (strobe) |
| state_o | output | 3 | Current state code |
| core_clk_en | output | 1 | Internal core clock enable |
| pll_en | output | 1 | PLL enable |
| snoop_ok | output | 1 | Snoops may be serviced |
| bclk_stop_ok | output | 1 | Bus clock may be stopped |
| proto_err | output | 1 | Protocol violation pulse |

## Verification
The bench builds the block with CLK_MHZ=1 and RELOCK_US=3, so the relock wait is three cycles. This makes the full wait and its early abort short enough to walk through cycle by cycle. BCLK_STOP_LAG=2 selects the registered permission path, which gives a visible one-cycle gap between entering deep sleep and granting the bus-clock stop. With these values every reachable state can be paired with all 128 combinations of the seven request inputs. Each pairing has its next state, violation pulse and output decode predicted.

// File: rtl/lps_pkg.sv
package lps_pkg;

   localparam int unsigned LP_STATE_W = 3;

   typedef enum logic [LP_STATE_W-1:0] {
      LP_RUN    = 3'd0,
      LP_STOPG  = 3'd1,
      LP_SNOOP  = 3'd2,
      LP_SLEEP  = 3'd3,
      LP_DEEP   = 3'd4,
      LP_RELOCK = 3'd5,
      LP_RESET  = 3'd6
   } lp_state_e;

   // Requests decoded to active-high form.
   typedef struct packed {
      logic clkstop;
      logic nap;
      logic deep;
      logic snoop_ev;   // snoop or interrupt arrival
      logic served;     // snoop serviced or interrupt latched
   } lp_req_t;

endpackage

// File: rtl/lps_relock_timer.sv
module lps_relock_timer #(
   parameter int unsigned CYCLES = 1500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic done
);
   localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

   logic [CW-1:0] cnt_q;

   initial assert (CYCLES >= 1) else $error("relock interval must be at least one cycle");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (load)                 cnt_q <= CW'(CYCLES - 1);
      else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

   // R8: the count falls by one each running cycle until it expires
   a_r8_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R8: an expired count stays expired until reloaded
   a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !load) |=> done);

endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
   import lps_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  lp_req_t   req,
   input  logic      relock_done,
   output lp_state_e state_q,
   output logic      relock_load,
   output logic      relock_run,
   output logic      viol_q
);
   lp_state_e nxt;
   logic      viol_d;

   always_comb begin
      nxt    = state_q;
      viol_d = 1'b0;
      unique case (state_q)
         LP_RUN: begin
            if (req.clkstop) nxt = LP_STOPG;
            viol_d = req.nap | req.deep;
         end
         LP_STOPG: begin
            if (req.snoop_ev)      nxt = LP_SNOOP;
            else if (req.nap)      nxt = LP_SLEEP;
            else if (!req.clkstop) nxt = LP_RUN;
            viol_d = req.deep;
         end
         LP_SNOOP: begin
            if (req.served) nxt = LP_STOPG;
            viol_d = req.nap | req.deep;
         end
         LP_SLEEP: begin
            if (req.deep)      nxt = LP_DEEP;
            else if (!req.nap) nxt = LP_STOPG;
            viol_d = req.snoop_ev;
         end
         LP_DEEP: begin
            if (!req.deep) nxt = LP_RELOCK;
            viol_d = req.snoop_ev;
         end
         LP_RELOCK: begin
            if (req.deep)         nxt = LP_DEEP;
            else if (relock_done) nxt = LP_SLEEP;
            viol_d = req.snoop_ev;
         end
         LP_RESET: nxt = LP_RUN;
         default:  nxt = LP_RESET;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LP_RESET;
         viol_q  <= 1'b0;
      end else begin
         state_q <= nxt;
         viol_q  <= viol_d;
      end
   end

   assign relock_load = (state_q == LP_DEEP) && !req.deep;
   assign relock_run  = (state_q == LP_RELOCK);

   // R5: sleep is never reached straight from run or snoop
   a_r5_sleep_source: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LP_RUN || state_q == LP_SNOOP) |=> (state_q != LP_SLEEP));

   // R8: deep-sleep release always passes through the relock wait
   a_r8_deep_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LP_DEEP && !req.deep) |=> (state_q == LP_RELOCK));

   // R9: bus activity in sleep flags a violation and the state holds
   a_r9_sleep_snoop: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LP_SLEEP && req.snoop_ev && req.nap && !req.deep)
      |=> (viol_q && state_q == LP_SLEEP));

   // R2: RESET always gives RUN at the next edge
   a_r2_leave_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LP_RESET) |=> (state_q == LP_RUN));

endmodule

// File: rtl/lps_out_decode.sv
module lps_out_decode
   import lps_pkg::*;
(
   input  lp_state_e state,
   output logic      core_clk_en,
   output logic      pll_en,
   output logic      snoop_ok
);
   always_comb begin
      core_clk_en = 1'b0;
      pll_en      = 1'b1;
      snoop_ok    = 1'b0;
      unique case (state)
         LP_RUN:   begin core_clk_en = 1'b1; snoop_ok = 1'b1; end
         LP_STOPG,
         LP_SNOOP: snoop_ok = 1'b1;
         LP_DEEP:  pll_en = 1'b0;
         default:  ;
      endcase
   end

   // R10: the core clock never runs with the PLL off
   always_comb begin
      a_r10_clk_needs_pll: assert (!(core_clk_en && !pll_en));
   end

endmodule

// File: rtl/lps_seq.sv
module lps_seq
   import lps_pkg::*;
#(
   parameter int unsigned CLK_MHZ       = 100,
   parameter int unsigned RELOCK_US     = 15,
   parameter int unsigned BCLK_STOP_LAG = 1
) (
   input  logic       clk,
   input  logic       rst_req_n,
   input  logic       clkstop_req_n,
   input  logic       nap_req_n,
   input  logic       deep_req_n,
   input  logic       snoop_req,
   input  logic       irq_req,
   input  logic       snoop_done,
   input  logic       irq_latched,
   output logic [2:0] state_o,
   output logic       core_clk_en,
   output logic       pll_en,
   output logic       snoop_ok,
   output logic       bclk_stop_ok,
   output logic       proto_err
);
   localparam int unsigned RELOCK_CYC = CLK_MHZ * RELOCK_US;

   initial assert (BCLK_STOP_LAG == 1 || BCLK_STOP_LAG == 2)
      else $error("bus-clock stop lag must be 1 or 2");

   lp_req_t   req;
   lp_state_e state;
   logic      relock_load, relock_run, relock_done;

   assign req.clkstop  = !clkstop_req_n;
   assign req.nap      = !nap_req_n;
   assign req.deep     = !deep_req_n;
   assign req.snoop_ev = snoop_req | irq_req;
   assign req.served   = snoop_done | irq_latched;

   lps_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_req_n),
      .req         (req),
      .relock_done (relock_done),
      .state_q     (state),
      .relock_load (relock_load),
      .relock_run  (relock_run),
      .viol_q      (proto_err)
   );

   lps_relock_timer #(.CYCLES(RELOCK_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_req_n),
      .load  (relock_load),
      .run   (relock_run),
      .done  (relock_done)
   );

   lps_out_decode u_dec (
      .state       (state),
      .core_clk_en (core_clk_en),
      .pll_en      (pll_en),
      .snoop_ok    (snoop_ok)
   );

   assign state_o = state;

   generate
      if (BCLK_STOP_LAG == 1) begin : g_stop_direct
         assign bclk_stop_ok = (state == LP_DEEP) && req.deep;

         // R11: permission follows the first edge in deep sleep
         a_r11_stop_lag1: assert property (@(posedge clk) disable iff (!rst_req_n)
            (state == LP_SLEEP && req.deep) |=> (bclk_stop_ok || !req.deep));
      end else begin : g_stop_reg
         logic stop_q;
         always_ff @(posedge clk or negedge rst_req_n) begin
            if (!rst_req_n) stop_q <= 1'b0;
            else            stop_q <= (state == LP_DEEP) && req.deep;
         end
         assign bclk_stop_ok = stop_q;

         // R11: permission by the second edge after the deep request
         a_r11_stop_lag2: assert property (@(posedge clk) disable iff (!rst_req_n)
            (state == LP_DEEP && req.deep) |=> bclk_stop_ok);
      end
   endgenerate

   // R11: the bus clock may stop only in deep sleep
   a_r11_stop_only_deep: assert property (@(posedge clk) disable iff (!rst_req_n)
      bclk_stop_ok |-> (state == LP_DEEP));

   // R12: the violation pulse lasts one cycle when the offence is withdrawn
   a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_req_n)
      (proto_err && state == LP_RUN && !req.nap && !req.deep) |=> !proto_err);

endmodule

// File: tb/sim_lps_seq.sv
module sim_lps_seq;
   localparam int MHZ = 1;
   localparam int US  = 3;
   localparam int LAG = 2;
   localparam int N   = MHZ * US;

   logic clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic rst_n, clk_n, nap_n, deep_n, snp, irq, sdone, ilat;
   logic [2:0] st;
   logic cen, pen, sok, bok, perr;
   int n_chk = 0, n_bad = 0;

   lps_seq #(.CLK_MHZ(MHZ), .RELOCK_US(US), .BCLK_STOP_LAG(LAG)) u0 (
      .clk(clk), .rst_req_n(rst_n), .clkstop_req_n(clk_n), .nap_req_n(nap_n),
      .deep_req_n(deep_n), .snoop_req(snp), .irq_req(irq), .snoop_done(sdone),
      .irq_latched(ilat), .state_o(st), .core_clk_en(cen), .pll_en(pen),
      .snoop_ok(sok), .bclk_stop_ok(bok), .proto_err(perr));

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle();
      clk_n = 1; nap_n = 1; deep_n = 1; snp = 0; irq = 0; sdone = 0; ilat = 0;
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0; idle();
      @(negedge clk); rst_n = 1;
      step();
   endtask

   // Reach state s (0..5) with the holding inputs in place.
   task automatic go(input int s);
      do_reset();
      if (s >= 1) begin clk_n = 0; step(); end
      if (s == 2) begin snp = 1; step(); snp = 0; end
      if (s >= 3) begin nap_n = 0; step(); end
      if (s >= 4) begin deep_n = 0; step(); end
      if (s == 5) begin deep_n = 1; step(); end
   endtask

   // Expected next state from R3..R9, freshly entered RELOCK.
   function automatic int exp_next(input int s, input logic [6:0] v);
      logic cs, np, dp, ev, sv;
      cs = !v[0]; np = !v[1]; dp = !v[2]; ev = v[3] | v[4]; sv = v[5] | v[6];
      case (s)
         0: return cs ? 1 : 0;
         1: return ev ? 2 : np ? 3 : !cs ? 0 : 1;
         2: return sv ? 1 : 2;
         3: return dp ? 4 : !np ? 1 : 3;
         4: return dp ? 4 : 5;
         default: return dp ? 4 : (N == 1) ? 3 : 5;
      endcase
   endfunction

   function automatic int exp_err(input int s, input logic [6:0] v);
      logic np, dp, ev;
      np = !v[1]; dp = !v[2]; ev = v[3] | v[4];
      case (s)
         0, 2: return int'(np | dp);
         1:    return int'(dp);
         default: return int'(ev);
      endcase
   endfunction

   function automatic string tag_of(input int s);
      case (s)
         0: return "R3";
         1, 2: return "R4";
         3: return "R6";
         4: return "R7";
         default: return "R8";
      endcase
   endfunction

   initial begin
      #(8 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog timeout");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      rst_n = 0; idle();
      @(negedge clk); @(negedge clk);
      // R2 / R1: reset state code and outputs
      chk("R1 reset code", st, 6);
      chk("R2 reset clk_en", cen, 0);
      chk("R2 reset bclk_stop", bok, 0);
      chk("R2 reset err", perr, 0);
      rst_n = 1; step();
      chk("R2 run after release", st, 0);

      // Sweep: every reachable state against all request combinations
      for (int s = 0; s <= 5; s++) begin
         for (int v = 0; v < 128; v++) begin
            int e;
            go(s);
            {ilat, sdone, irq, snp, deep_n, nap_n, clk_n} = 7'(v);
            step();
            e = exp_next(s, 7'(v));
            chk({tag_of(s), " next state"}, st, e);
            chk("R12 violation pulse", perr, exp_err(s, 7'(v)));
            chk("R10 clk_en", cen, int'(e == 0));
            chk("R10 pll_en", pen, int'(e != 4));
            chk("R10 snoop_ok", sok, int'(e <= 2));
         end
      end

      // R5: sleep request in run is refused and flagged
      go(0); nap_n = 0; step();
      chk("R5 stay run", st, 0); chk("R5 flag", perr, 1);
      nap_n = 1; step();
      chk("R12 pulse ends", perr, 0);

      // R7: deep request in stop-grant is flagged
      go(1); deep_n = 0; step();
      chk("R7 stay stop-grant", st, 1); chk("R7 flag", perr, 1);

      // R9: snoop in deep sleep
      go(4); snp = 1; step(); snp = 0;
      chk("R9 stay deep", st, 4); chk("R9 flag", perr, 1);

      // R8: full relock length
      go(5);
      for (int i = 1; i < N; i++) begin
         step(); chk("R8 still relocking", st, 5);
      end
      step(); chk("R8 sleep after relock", st, 3);

      // R8: abort mid-relock, then a full wait again
      go(5); step(); deep_n = 0; step();
      chk("R8 back to deep", st, 4);
      deep_n = 1; step(); chk("R8 relock again", st, 5);
      for (int i = 1; i < N; i++) begin
         step(); chk("R8 full second wait", st, 5);
      end
      step(); chk("R8 second sleep", st, 3);

      // R11: bus-clock stop permission timing
      go(3); deep_n = 0; step();
      chk("R11 deep entered", st, 4);
      chk("R11 not yet", bok, 0);
      step(); chk("R11 granted", bok, 1);
      deep_n = 1; step();
      chk("R11 withdrawn", bok, 0);

      // R2: reset from sleep acts at once
      go(3); rst_n = 0; #1;
      chk("R2 reset from sleep", st, 6);
      @(negedge clk); idle(); rst_n = 1; step();
      chk("R2 run after sleep reset", st, 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule